// File: doc/BRIEF.md
# SPI Host Controller with Register Window

This block is a host-only SPI controller that software runs through a small 32-bit register window. Words written to a transmit data port queue in a transmit FIFO. A full-duplex shift engine moves each word out on the serial data line and captures one word from the serial input in return. Each captured word is queued in a receive FIFO, where software reads it back through a receive data port.

A control register selects clock polarity and phase, bit order and internal loopback. It also holds the enable and host-mode bits and a transfer-inhibit bit. Software sets inhibit, preloads a burst and then clears the bit, and the queued words go out back to back. The select lines follow a register bit for bit. The serial clock rate is a build-time divider that software cannot change. Software can find the transmit FIFO depth by writing words while the engine is stopped until the full flag sets.

Top module: `spi_host_engine`

## Requirements
- R1: After reset the status register (offset 0x64) reads 0x05: bit0 is RX empty, bit1 RX full, bit2 TX empty, bit3 TX full, and bit4, the mode fault bit, always reads 0. The control register (offset 0x60) reads 0 and SCK is low.
- R2: The control register keeps bit0 loopback, bit1 enable, bit2 host mode, bit3 CPOL, bit4 CPHA, bit7 manual select, bit8 transfer inhibit and bit9 LSB first. Writing 0x3FF reads back 0x39F.
- R3: A write to offset 0x68 queues the low data bits in the TX FIFO. With the engine stopped, the TX full flag sets after exactly DEPTH writes, and further writes are dropped.
- R4: While control bit8 is set, queued words stay in the TX FIFO and SCK holds its idle level. Clearing bit8 sends all of them.
- R5: Every word sent produces exactly one received word in the RX FIFO, read in order at offset 0x6C. With loopback set (bit0), each received word equals the word sent.
- R6: SCK idles at the CPOL level, and transfers work in all four CPOL/CPHA modes. With CPHA=0, data is valid at the leading SCK edge; with CPHA=1, at the trailing edge.
- R7: Bits leave MSB first when control bit9 is 0 and LSB first when it is 1. A received word is reassembled in the same order.
- R8: Control bit5 empties the TX FIFO and bit6 empties the RX FIFO. Both act within one clock and always read back as 0.
- R9: Reading offset 0x6C while the RX FIFO is empty returns 0 and leaves the FIFO unchanged.
- R10: The select register (offset 0x70) resets to all ones. Its low NSEL bits drive ss_n directly and read back zero-extended.
- R11: A word that completes while the RX FIFO is full is dropped. The words already held are kept.
- R12: A new word starts shifting only when enable (bit1) and host mode (bit2) are both set and inhibit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a read of 0x6C pops the RX FIFO at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Select lines, straight from the select register |

## Verification
The assertions assume single-cycle bus strobes and no read and write in the same cycle. They also assume CPOL, CPHA and the bit-order bit stay unchanged while a word is in flight. The bench changes the control register only after the engine has had time to go idle. Bus accesses come from tasks that pulse one strobe per access on the falling clock edge. Random bursts never exceed the FIFO depth, so only the directed overrun case drives the RX FIFO past full.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SEL  = 8'h70;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_HOST  = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_MSEL  = 7;
  localparam int CB_INH   = 8;
  localparam int CB_LSB   = 9;
  localparam int CTRL_W   = 10;

  // reverse the low w bits of v, zero above
  function automatic logic [31:0] rev_bits(input logic [31:0] v, input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i < w) r[i] = v[w-1-i];
    return r;
  endfunction

  // control bits that are stored (pulse bits excluded)
  function automatic logic [CTRL_W-1:0] ctrl_keep(input logic [CTRL_W-1:0] v);
    logic [CTRL_W-1:0] m;
    m = '1;
    m[CB_TXCLR] = 1'b0;
    m[CB_RXCLR] = 1'b0;
    return v & m;
  endfunction
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic [AW:0]  count;
  logic         do_push, do_pop;

  assign count   = wptr - rptr;
  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end

  // R3 / R11: a push into a full FIFO leaves the fill level alone
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));

  // R9: a pop from an empty FIFO leaves the fill level alone
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (count == $past(count)));

  // R8: clear empties the FIFO on the next edge
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         go,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_word,
  output logic         tx_pop,
  input  logic         miso,
  output logic [W-1:0] rx_word,
  output logic         rx_push,
  output logic         sck,
  output logic         mosi,
  output logic         busy
);
  localparam int EW = $clog2(2*W);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*W-1);
  localparam logic [DW-1:0] LAST_DIV  = DW'(DIV-1);

  logic          busy_q, fin_q, sck_q, cpha_q, lsb_q;
  logic [DW-1:0] div_cnt;
  logic [EW-1:0] edge_cnt;
  logic [W-1:0]  tsr, rsr;
  logic          tick, lead_edge, do_sample, do_shift;

  assign tick      = busy_q && (div_cnt == LAST_DIV);
  assign lead_edge = !edge_cnt[0];
  assign do_sample = tick && (lead_edge ? !cpha_q : cpha_q);
  assign do_shift  = tick && (lead_edge ? (cpha_q && edge_cnt != '0) : !cpha_q);
  assign tx_pop    = !busy_q && !fin_q && go && tx_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      sck_q    <= 1'b0;
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tsr      <= '0;
      rsr      <= '0;
    end else begin
      fin_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= cpol;
        if (tx_pop) begin
          busy_q   <= 1'b1;
          cpha_q   <= cpha;
          lsb_q    <= lsb_first;
          div_cnt  <= '0;
          edge_cnt <= '0;
          tsr      <= lsb_first ? W'(rev_bits(32'(tx_word), W)) : tx_word;
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          sck_q    <= ~sck_q;
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == LAST_EDGE) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b1;
          end
        end
        if (do_sample) rsr <= {rsr[W-2:0], miso};
        if (do_shift)  tsr <= {tsr[W-2:0], 1'b0};
      end
    end
  end

  assign rx_word = lsb_q ? W'(rev_bits(32'(rsr), W)) : rsr;
  assign rx_push = fin_q;
  assign sck     = sck_q;
  assign mosi    = tsr[W-1];
  assign busy    = busy_q;

  // R12: a word only starts when the gate is open
  assert_start_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go));

  // R6: while idle with a steady CPOL, SCK sits at CPOL
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q) && $stable(cpol)) |-> (sck == cpol));

  // R5: every finished word came from a shifting period
  assert_one_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 4,
  parameter int DIV    = 2,
  parameter int NSEL   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   ss_n
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NSEL-1:0]   sel_q;
  logic              hit_ctrl, hit_txd, hit_rxd, hit_sel;
  logic              tx_clr, rx_clr, tx_push, rx_pop;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [W-1:0]      tx_head, rx_head, rx_word;
  logic              tx_pop, rx_push, go, miso_int, busy, mosi_int;
  logic [31:0]       status;

  assign hit_ctrl = (reg_addr == ADDR_W'(OFF_CTRL));
  assign hit_txd  = (reg_addr == ADDR_W'(OFF_TXD));
  assign hit_rxd  = (reg_addr == ADDR_W'(OFF_RXD));
  assign hit_sel  = (reg_addr == ADDR_W'(OFF_SEL));

  assign tx_clr  = reg_wr && hit_ctrl && reg_wdata[CB_TXCLR];
  assign rx_clr  = reg_wr && hit_ctrl && reg_wdata[CB_RXCLR];
  assign tx_push = reg_wr && hit_txd;
  assign rx_pop  = reg_rd && hit_rxd;
  assign go      = ctrl_q[CB_EN] && ctrl_q[CB_HOST] && !ctrl_q[CB_INH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '1;
    end else if (reg_wr) begin
      if (hit_ctrl) ctrl_q <= ctrl_keep(reg_wdata[CTRL_W-1:0]);
      if (hit_sel)  sel_q  <= reg_wdata[NSEL-1:0];
    end
  end

  spi_host_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .din(reg_wdata[W-1:0]),
    .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full)
  );

  spi_host_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  assign miso_int = ctrl_q[CB_LOOP] ? mosi_int : miso;

  spi_host_shifter #(.W(W), .DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]), .lsb_first(ctrl_q[CB_LSB]),
    .go(go), .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .miso(miso_int), .rx_word(rx_word), .rx_push(rx_push),
    .sck(sck), .mosi(mosi_int), .busy(busy)
  );

  assign mosi = mosi_int;
  assign ss_n = sel_q;

  assign status = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) reg_rdata = 32'(ctrl_q);
    if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata = status;
    if (hit_rxd && !rx_empty) reg_rdata = 32'(rx_head);
    if (hit_sel) reg_rdata = 32'(sel_q);
  end

  wire unused_inputs = ^{reg_wdata, busy};

  // R8: a TX reset request leaves the TX FIFO empty next cycle
  assert_tx_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> tx_empty);

  // R8: the pulse bits are never held in the control register
  assert_pulse_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && hit_ctrl) |-> (reg_rdata[CB_TXCLR] == 1'b0 || !hit_ctrl));

  // R10: select lines follow the last select write
  assert_sel_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_sel) |=> (ss_n == $past(reg_wdata[NSEL-1:0])));

  // R9: empty RX read returns zero
  assert_rx_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/tb_spi_host_engine.sv
module tb_spi_host_engine;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int WORD_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, miso = 1'b0;
  logic [3:0]  ss_n;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  spi_host_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #2.5 clk = ~clk;

  // serial sniffer: collects MOSI at the sampling edge of the current mode
  logic         cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic         sck_prev = 1'b0;
  logic [W-1:0] snif = '0;
  always @(negedge clk) begin
    if (sck !== sck_prev) begin
      if ((sck_prev == cur_cpol) != cur_cpha) snif = {snif[W-2:0], mosi};
    end
    sck_prev = sck;
  end

  function automatic logic [W-1:0] wire_order(input logic [W-1:0] v, input bit lsb);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = lsb ? v[W-1-i] : v[i];
    return r;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit loop, en, host, cpol, cpha, inh, lsb);
    return (32'(loop)) | (32'(en) << 1) | (32'(host) << 2) | (32'(cpol) << 3) |
           (32'(cpha) << 4) | (32'(inh) << 8) | (32'(lsb) << 9);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [W-1:0] words [DEPTH];
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h64, d); check(d == 32'h5, "R1 status", d, 32'h5);
    rd(8'h60, d); check(d == 32'h0, "R1 ctrl", d, 32'h0);
    check(sck == 1'b0, "R1 sck", 32'(sck), 32'h0);
    // R10 select reset and direct drive
    check(ss_n == 4'hF, "R10 reset", 32'(ss_n), 32'hF);
    wr(8'h70, 32'hFFFF_FFF5);
    check(ss_n == 4'h5, "R10 drive", 32'(ss_n), 32'h5);
    rd(8'h70, d); check(d == 32'h5, "R10 readback", d, 32'h5);
    wr(8'h70, 32'hFFFF_FFFF);
    check(ss_n == 4'hF, "R10 deselect", 32'(ss_n), 32'hF);

    // R9 empty read returns zero and status stays empty
    rd(8'h6C, d); check(d == 32'h0, "R9 empty read", d, 32'h0);
    rd(8'h64, d); check(d[0] == 1'b1, "R9 still empty", d, 32'h5);

    // R3 depth discovery while stopped
    n = 0;
    do begin
      wr(8'h68, 32'(n + 1));
      n++;
      rd(8'h64, d);
    end while (!d[3] && n < 16);
    check(n == DEPTH, "R3 depth", 32'(n), 32'(DEPTH));
    wr(8'h68, 32'hEE);
    cur_cpol = 0; cur_cpha = 0;
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 0, 0));
    idle(DEPTH * WORD_CYC + 20);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h6C, d); check(d == 32'(i + 1), "R3 R5 queued word", d, 32'(i + 1));
    end
    rd(8'h64, d); check(d[0] == 1'b1, "R3 extra write dropped", d, 32'h5);

    // R4 inhibit holds words
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 0));
    wr(8'h68, 32'hA5); wr(8'h68, 32'h3C);
    idle(100);
    rd(8'h64, d); check(d[2] == 1'b0 && d[0] == 1'b1, "R4 held", d, 32'h1);
    check(sck == 1'b0, "R4 sck idle", 32'(sck), 32'h0);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 0, 0));
    idle(2 * WORD_CYC + 20);
    rd(8'h6C, d); check(d == 32'hA5, "R4 first", d, 32'hA5);
    rd(8'h6C, d); check(d == 32'h3C, "R4 second", d, 32'h3C);

    // R12 no shifting without enable or host mode
    wr(8'h60, ctrl_word(1, 1, 0, 0, 0, 0, 0));
    wr(8'h68, 32'h11);
    idle(WORD_CYC + 10);
    rd(8'h64, d); check(d[2] == 1'b0, "R12 host clear", d, 32'h1);
    wr(8'h60, ctrl_word(1, 0, 1, 0, 0, 0, 0));
    idle(WORD_CYC + 10);
    rd(8'h64, d); check(d[2] == 1'b0 && d[0], "R12 enable clear", d, 32'h1);

    // R8 TX reset self-clears
    wr(8'h60, ctrl_word(1, 0, 1, 0, 0, 0, 0) | 32'h20);
    rd(8'h64, d); check(d[2] == 1'b1, "R8 tx emptied", d, 32'h5);
    rd(8'h60, d); check(d == 32'h5, "R8 ctrl readback", d, 32'h5);

    // R2 control field storage
    wr(8'h60, 32'h3FF);
    rd(8'h60, d); check(d == 32'h39F, "R2 ctrl bits", d, 32'h39F);

    // R11 overrun drops late words; R8 RX reset
    wr(8'h60, 32'h60);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 0, 0));
    for (int i = 0; i < DEPTH; i++) wr(8'h68, 32'h40 + i);
    idle(DEPTH * WORD_CYC + 20);
    wr(8'h68, 32'h77); wr(8'h68, 32'h78);
    idle(2 * WORD_CYC + 20);
    rd(8'h64, d); check(d[1] == 1'b1 && d[2], "R11 rx full", d, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h6C, d); check(d == 32'h40 + i, "R11 kept", d, 32'h40 + i);
    end
    rd(8'h64, d); check(d[0] == 1'b1, "R11 late dropped", d, 32'h5);
    wr(8'h68, 32'h99);
    idle(WORD_CYC + 10);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 0, 0) | 32'h40);
    rd(8'h64, d); check(d[0] == 1'b1, "R8 rx emptied", d, 32'h5);

    // R7 directed bit order on the wire
    for (int lsb = 0; lsb < 2; lsb++) begin
      wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 0, lsb[0]));
      idle(3); snif = '0;
      wr(8'h68, 32'h81 + 32'h10);
      idle(WORD_CYC + 10);
      check(snif == wire_order(8'h91, lsb[0]), "R7 order", 32'(snif), 32'(wire_order(8'h91, lsb[0])));
      rd(8'h6C, d); check(d == 32'h91, "R7 reassembled", d, 32'h91);
    end

    // R5 R6 R7 random modes and bursts
    void'($urandom(32'h5EED));
    for (int it = 0; it < 24; it++) begin
      bit cp, ch, lb;
      int cnt;
      cp = $urandom_range(0, 1); ch = $urandom_range(0, 1); lb = $urandom_range(0, 1);
      cnt = $urandom_range(1, DEPTH);
      cur_cpol = cp; cur_cpha = ch;
      wr(8'h60, ctrl_word(1, 1, 1, cp, ch, 0, lb));
      idle(3);
      check(sck == cp, "R6 idle level", 32'(sck), 32'(cp));
      snif = '0;
      for (int k = 0; k < cnt; k++) begin
        words[k] = W'($urandom);
        wr(8'h68, 32'(words[k]));
      end
      idle(cnt * WORD_CYC + 20);
      if (cnt == 1)
        check(snif == wire_order(words[0], lb), "R6 R7 wire bits", 32'(snif), 32'(wire_order(words[0], lb)));
      for (int k = 0; k < cnt; k++) begin
        rd(8'h6C, d); check(d == 32'(words[k]), "R5 loopback", d, 32'(words[k]));
      end
      rd(8'h64, d); check(d[0] && d[2], "R5 counts match", d, 32'h5);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule